// File: doc/BRIEF.md
# SPI Flash Software-Driven Transaction Engine

This block lets software run one serial flash transaction at a time over a single-lane SPI link. Software first loads a command byte, three address bytes and four data bytes through a byte-wide register port. It then writes a control byte. That control byte sets the shape of the transaction: whether a command is sent, whether an address is sent, how many data bytes move (zero to four), which way they move, and which device is targeted. Writing it with its top bit set starts the transaction. The engine drives SCK, MOSI and one of two active-low chip selects in SPI mode 0. It runs the phases in a fixed order: command, then address, then data. Bytes read from the flash land in the data registers. The top bit of the control byte reads back as 1 while the engine is working and falls to 0 when it is done.

A second control byte holds three kinds of bit:
- a software level for each chip select, so software can keep a device selected across several short transactions and build a longer flash operation;
- a bit that sends the automatic select to the second device;
- a lock bit that freezes the transaction fields.

The SCK half period is a fixed number of system clocks, set by a parameter.

Top module: `flash_uxfer_engine`

## Requirements
- R1: After reset, the control byte reads 0x00, the extended byte reads 0x03, both chip selects are high and SCK is low.
- R2: Register offsets are fixed. 0x16 is the command byte. 0x17, 0x18 and 0x19 are address bytes 0, 1 and 2. 0x1A to 0x1D are data bytes 0 to 3. 0x1E is the control byte and 0x1F is the extended byte. Offsets 0x20 to 0x23 are a second view of data bytes 0 to 3, for both reads and writes. Any other offset reads 0.
- R3: The control byte has these fields: bit 4 set skips the command byte; bit 3 set adds three address bytes. Phases run in this order: command, then address (byte 2, byte 1, byte 0), then data. Each byte goes out MSB first. MOSI changes only while SCK is low, and MISO is sampled on the rising edge of SCK.
- R4: Control bits 2:0 give the data byte count. Values 5 to 7 act as 4. When bit 5 is set, data bytes 0 and up are sent. When bit 5 is clear, MOSI is held low and the received bytes go into data byte 0 and up. Data bytes that are not read keep their values.
- R5: Writing the control byte with bit 7 set, while idle, starts a transaction. Bit 7 reads 1 until the transaction ends, then reads 0. The other control bits read back as written. A transaction with no bytes produces no SCK pulse but still completes.
- R6: During a transaction, the engine drives one chip select low by itself. It uses cs_n[1] when control bit 6 is 1 or extended bit 2 is 1; otherwise it uses cs_n[0]. The select goes low at least one SCK half period before the first rising edge, stays low at least one half period after the last falling edge, and is high when idle.
- R7: Extended bits 0 and 1 are software levels for cs_n[0] and cs_n[1]. A 0 drives that select low whether or not a transaction is running. This lets a device stay selected across several transactions.
- R8: While a transaction is running, writes to the command, address, data and control registers have no effect. The extended byte can still be written.
- R9: While extended bit 3 (lock) is set, writes to the command, address and data registers have no effect. The control and extended bytes can still be written.
- R10: SCK stays high for exactly HALF_DIV system clocks per pulse, and stays low for at least HALF_DIV clocks between pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 6 | Register byte offset |
| reg_we | input | 1 | Register write strobe, one clock per write |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from reg_addr |
| spi_sck | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |
| spi_cs_n | output | 2 | Active-low chip selects for devices 0 and 1 |

## Verification
Faults show up at the pins within one transaction:
- A sequencer with a wrong byte index or wrong phase order makes MOSI carry misordered bytes, or the wrong number of SCK pulses, within that transaction.
- A bad capture index puts received data in the wrong data register. This is seen at the first readback after the transaction.
- A broken freeze or lock rule shows as a changed readback of the command or data register right after the blocked write, or as a different command byte on the wire in the same transaction.
- Timing faults in the divider or the chip-select window are caught at the first SCK edge or chip-select edge that breaks the half-period rule.

// File: rtl/fux_pkg.sv
package fux_pkg;
   localparam int unsigned REG_AW    = 6;
   localparam int unsigned ADR_BYTES = 3;
   localparam int unsigned DAT_BYTES = 4;
   localparam int unsigned DAT_IW    = $clog2(DAT_BYTES);
   localparam int unsigned CS_COUNT  = 2;

   localparam logic [REG_AW-1:0] OFF_CMD  = 6'h16;
   localparam logic [REG_AW-1:0] OFF_ADR0 = 6'h17;
   localparam logic [REG_AW-1:0] OFF_DAT0 = 6'h1A;
   localparam logic [REG_AW-1:0] OFF_CTL  = 6'h1E;
   localparam logic [REG_AW-1:0] OFF_EXT  = 6'h1F;
   localparam logic [REG_AW-1:0] OFF_WIDE = 6'h20;

   // transaction shape, bits 6:0 of the control byte
   typedef struct packed {
      logic       dev;
      logic       wr;
      logic       nocmd;
      logic       adr;
      logic [2:0] cnt;
   } ctl_t;

   // extended byte, bits 3:0
   typedef struct packed {
      logic       lock;
      logic       alt_cs;
      logic [1:0] sw_cs;
   } ext_t;

   typedef enum logic [2:0] {
      ST_IDLE, ST_SETUP, ST_LOAD, ST_XFER, ST_HOLD
   } st_t;
endpackage

// File: rtl/fux_regs.sv
module fux_regs
   import fux_pkg::*;
(
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [REG_AW-1:0]              bus_addr,
   input  logic                           bus_we,
   input  logic [7:0]                     bus_wdata,
   output logic [7:0]                     bus_rdata,
   input  logic                           busy,
   input  logic                           eng_we,
   input  logic [DAT_IW-1:0]              eng_idx,
   input  logic [7:0]                     eng_data,
   output logic                           start,
   output logic [7:0]                     cmd_q,
   output logic [ADR_BYTES-1:0][7:0]      adr_q,
   output logic [DAT_BYTES-1:0][7:0]      dat_q,
   output ctl_t                           ctl_q,
   output ext_t                           ext_q
);
   logic bus_ok, fld_ok;
   assign bus_ok = bus_we && !busy;
   assign fld_ok = bus_ok && !ext_q.lock;
   assign start  = bus_ok && (bus_addr == OFF_CTL) && bus_wdata[7];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q <= '0;
         ctl_q <= '0;
         ext_q <= ext_t'(4'b0011);
      end else begin
         if (fld_ok && bus_addr == OFF_CMD) cmd_q <= bus_wdata;
         if (bus_ok && bus_addr == OFF_CTL) ctl_q <= ctl_t'(bus_wdata[6:0]);
         if (bus_we && bus_addr == OFF_EXT) ext_q <= ext_t'(bus_wdata[3:0]);
      end
   end

   for (genvar k = 0; k < ADR_BYTES; k++) begin : g_adr
      logic [7:0] r;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) r <= '0;
         else if (fld_ok && bus_addr == OFF_ADR0 + REG_AW'(k)) r <= bus_wdata;
      end
      assign adr_q[k] = r;
   end

   for (genvar k = 0; k < DAT_BYTES; k++) begin : g_dat
      logic [7:0] r;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) r <= '0;
         else if (eng_we && eng_idx == DAT_IW'(k)) r <= eng_data;
         else if (fld_ok && (bus_addr == OFF_DAT0 + REG_AW'(k) ||
                             bus_addr == OFF_WIDE + REG_AW'(k))) r <= bus_wdata;
      end
      assign dat_q[k] = r;
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == OFF_CMD) bus_rdata = cmd_q;
      if (bus_addr == OFF_CTL) bus_rdata = {busy, ctl_q};
      if (bus_addr == OFF_EXT) bus_rdata = {4'b0000, ext_q};
      for (int k = 0; k < ADR_BYTES; k++)
         if (bus_addr == OFF_ADR0 + REG_AW'(k)) bus_rdata = adr_q[k];
      for (int k = 0; k < DAT_BYTES; k++)
         if (bus_addr == OFF_DAT0 + REG_AW'(k) || bus_addr == OFF_WIDE + REG_AW'(k))
            bus_rdata = dat_q[k];
   end

   // R8: transaction fields hold still while the engine runs
   p_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
      busy && $past(busy) |-> $stable(cmd_q) && $stable(adr_q) && $stable(ctl_q));
   // R9: locked fields ignore bus writes
   p_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $past(ext_q.lock) |-> $stable(cmd_q) && $stable(adr_q));
endmodule

// File: rtl/fux_tick.sv
module fux_tick #(
   parameter int unsigned HALF_DIV = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic restart,
   output logic tick
);
   if (HALF_DIV < 1) begin : g_bad
      $fatal(1, "HALF_DIV must be at least 1");
   end

   if (HALF_DIV == 1) begin : g_every
      assign tick = run && !restart;
   end else begin : g_count
      localparam int unsigned CW = $clog2(HALF_DIV);
      localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);
      logic [CW-1:0] cnt;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                 cnt <= '0;
         else if (restart || !run)   cnt <= '0;
         else if (cnt == LAST)       cnt <= '0;
         else                        cnt <= cnt + 1'b1;
      end
      assign tick = run && !restart && (cnt == LAST);

      // R10: ticks are spaced, never back to back
      p_tick_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
         tick |=> !tick);
   end
endmodule

// File: rtl/fux_shift.sv
module fux_shift (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       load,
   input  logic [7:0] load_byte,
   input  logic       tick,
   input  logic       miso,
   output logic       sck,
   output logic       mosi,
   output logic [7:0] rx_byte,
   output logic       byte_done
);
   logic [7:0] sh;
   logic [2:0] bitn;
   logic       act;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh <= '0; bitn <= '0; act <= 1'b0; sck <= 1'b0;
         rx_byte <= '0; byte_done <= 1'b0;
      end else begin
         byte_done <= 1'b0;
         if (load) begin
            sh <= load_byte; bitn <= '0; act <= 1'b1; sck <= 1'b0;
         end else if (act && tick) begin
            if (!sck) begin
               sck     <= 1'b1;
               rx_byte <= {rx_byte[6:0], miso};
            end else begin
               sck  <= 1'b0;
               sh   <= {sh[6:0], 1'b0};
               bitn <= bitn + 1'b1;
               if (bitn == 3'd7) begin
                  act       <= 1'b0;
                  byte_done <= 1'b1;
               end
            end
         end
      end
   end
   assign mosi = sh[7];

   // R3: mode 0, data never moves while the clock is high or on its rise
   p_mosi_steady_r3: assert property (@(posedge clk) disable iff (!rst_n)
      sck |-> $stable(mosi));
   p_done_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
      byte_done |-> !sck);
endmodule

// File: rtl/fux_seq.sv
module fux_seq
   import fux_pkg::*;
(
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      start,
   input  logic                      c_nocmd,
   input  logic                      c_adr,
   input  logic                      c_wr,
   input  logic [2:0]                c_cnt,
   input  logic [7:0]                cmd,
   input  logic [ADR_BYTES-1:0][7:0] adr,
   input  logic [DAT_BYTES-1:0][7:0] dat,
   input  logic                      tick,
   input  logic                      byte_done,
   input  logic [7:0]                rx_byte,
   output logic                      busy,
   output logic                      load,
   output logic [7:0]                load_byte,
   output logic                      eng_we,
   output logic [DAT_IW-1:0]         eng_idx,
   output logic [7:0]                eng_data
);
   st_t        st;
   logic [3:0] idx, n_cmd, n_adr, n_dat, total, a_off;
   logic [1:0] asel;
   logic [DAT_IW-1:0] dsel;
   logic [7:0] byte_out;
   logic       is_rd;

   assign n_cmd = c_nocmd ? 4'd0 : 4'd1;
   assign n_adr = c_adr ? 4'(ADR_BYTES) : 4'd0;
   assign n_dat = (c_cnt > 3'(DAT_BYTES)) ? 4'(DAT_BYTES) : {1'b0, c_cnt};
   assign total = n_cmd + n_adr + n_dat;
   assign a_off = idx - n_cmd;
   assign asel  = 2'(4'(ADR_BYTES - 1) - a_off);
   assign dsel  = DAT_IW'(idx - n_cmd - n_adr);

   always_comb begin
      byte_out = 8'h00;
      is_rd    = 1'b0;
      if (!c_nocmd && idx == 4'd0)   byte_out = cmd;
      else if (idx < n_cmd + n_adr)  byte_out = adr[asel];
      else if (c_wr)                 byte_out = dat[dsel];
      else                           is_rd    = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st  <= ST_IDLE;
         idx <= '0;
      end else begin
         case (st)
            ST_IDLE:  if (start) begin st <= ST_SETUP; idx <= '0; end
            ST_SETUP: if (tick) st <= (total == 4'd0) ? ST_HOLD : ST_LOAD;
            ST_LOAD:  st <= ST_XFER;
            ST_XFER:  if (byte_done) begin
                         if (idx == total - 4'd1) st <= ST_HOLD;
                         else begin idx <= idx + 4'd1; st <= ST_LOAD; end
                      end
            ST_HOLD:  if (tick) st <= ST_IDLE;
            default:  st <= ST_IDLE;
         endcase
      end
   end

   assign busy      = (st != ST_IDLE);
   assign load      = (st == ST_LOAD);
   assign load_byte = is_rd ? 8'h00 : byte_out;
   assign eng_we    = (st == ST_XFER) && byte_done && is_rd;
   assign eng_idx   = dsel;
   assign eng_data  = rx_byte;

   // R5: a start is followed by a busy engine
   p_start_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> busy);
   // R4: captures only happen in a read data phase and within the count
   p_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
      eng_we |-> !c_wr && (idx < total));
endmodule

// File: rtl/flash_uxfer_engine.sv
module flash_uxfer_engine
   import fux_pkg::*;
#(
   parameter int unsigned HALF_DIV = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic              reg_we,
   input  logic [7:0]        reg_wdata,
   output logic [7:0]        reg_rdata,
   output logic              spi_sck,
   output logic              spi_mosi,
   input  logic              spi_miso,
   output logic [1:0]        spi_cs_n
);
   if (CS_COUNT != 2) begin : g_cs_bad
      $fatal(1, "extended byte carries exactly two select levels");
   end

   logic busy, start, tick, load, byte_done, eng_we, auto_dev;
   logic [7:0] load_byte, rx_byte, eng_data, cmd_q;
   logic [DAT_IW-1:0] eng_idx;
   logic [ADR_BYTES-1:0][7:0] adr_q;
   logic [DAT_BYTES-1:0][7:0] dat_q;
   ctl_t ctl_q;
   ext_t ext_q;

   fux_regs u_regs (
      .clk, .rst_n, .bus_addr(reg_addr), .bus_we(reg_we), .bus_wdata(reg_wdata),
      .bus_rdata(reg_rdata), .busy, .eng_we, .eng_idx, .eng_data, .start,
      .cmd_q, .adr_q, .dat_q, .ctl_q, .ext_q
   );

   fux_tick #(.HALF_DIV(HALF_DIV)) u_tick (
      .clk, .rst_n, .run(busy), .restart(start | load | byte_done), .tick
   );

   fux_shift u_shift (
      .clk, .rst_n, .load, .load_byte, .tick, .miso(spi_miso),
      .sck(spi_sck), .mosi(spi_mosi), .rx_byte, .byte_done
   );

   fux_seq u_seq (
      .clk, .rst_n, .start, .c_nocmd(ctl_q.nocmd), .c_adr(ctl_q.adr),
      .c_wr(ctl_q.wr), .c_cnt(ctl_q.cnt), .cmd(cmd_q), .adr(adr_q), .dat(dat_q),
      .tick, .byte_done, .rx_byte, .busy, .load, .load_byte,
      .eng_we, .eng_idx, .eng_data
   );

   assign auto_dev = ext_q.alt_cs | ctl_q.dev;
   for (genvar i = 0; i < CS_COUNT; i++) begin : g_cs
      assign spi_cs_n[i] = ext_q.sw_cs[i] & ~(busy && (auto_dev == 1'(i)));
   end

   // R6: clocking only with some device selected
   p_sck_selected_r6: assert property (@(posedge clk) disable iff (!rst_n)
      spi_sck |-> (spi_cs_n != 2'b11));
   // R5: clock idles low outside transactions
   p_idle_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !spi_sck);
endmodule

// File: tb/tb_flash_uxfer_engine.sv
module tb_flash_uxfer_engine;
   localparam int HALF = 2;

   logic clk = 1'b0, rst_n = 1'b0;
   always #2 clk = ~clk;

   logic [5:0] reg_addr = '0;
   logic       reg_we = 1'b0;
   logic [7:0] reg_wdata = '0;
   wire  [7:0] reg_rdata;
   wire        spi_sck, spi_mosi;
   wire  [1:0] spi_cs_n;
   logic       spi_miso;

   flash_uxfer_engine #(.HALF_DIV(HALF)) dut (
      .clk, .rst_n, .reg_addr, .reg_we, .reg_wdata, .reg_rdata,
      .spi_sck, .spi_mosi, .spi_miso, .spi_cs_n
   );

   int n_chk = 0, n_bad = 0;

   // flash model: response stream indexed by byte position since last reset
   int sbit = 0;
   logic [7:0] salt = '0;
   function automatic logic [7:0] resp(int pos, logic [7:0] s);
      return 8'h3C ^ 8'(pos * 91) ^ s;
   endfunction
   function automatic logic miso_of(int b, logic [7:0] s);
      logic [7:0] r;
      r = resp(b / 8, s);
      return r[7 - (b % 8)];
   endfunction
   assign spi_miso = miso_of(sbit, salt);
   always @(negedge spi_sck) sbit = sbit + 1;

   logic [7:0] mlog [16];
   int mbits = 0, cs_bad = 0;
   logic [1:0] exp_cs = 2'b11;
   always @(posedge spi_sck) begin
      if (mbits < 128) mlog[mbits / 8][7 - (mbits % 8)] = spi_mosi;
      mbits = mbits + 1;
      if (spi_cs_n != exp_cs) cs_bad = cs_bad + 1;
   end

   // timing monitor, sampled between edges
   int cs_run = 0, hi_run = 0, lo_run = 0;
   int setup_bad = 0, hold_bad = 0, hi_bad = 0, lo_bad = 0;
   logic sck_d = 1'b0, csl_d = 1'b0;
   always @(negedge clk) if (rst_n) begin
      if (spi_sck && !sck_d) begin
         if (cs_run < HALF) setup_bad++;
         if (lo_run < HALF) lo_bad++;
      end
      if (!spi_sck && sck_d && hi_run != HALF) hi_bad++;
      if (spi_cs_n == 2'b11 && csl_d && lo_run < HALF) hold_bad++;
      cs_run = (spi_cs_n != 2'b11) ? cs_run + 1 : 0;
      hi_run = spi_sck ? hi_run + 1 : 0;
      lo_run = spi_sck ? 0 : lo_run + 1;
      sck_d  = spi_sck;
      csl_d  = (spi_cs_n != 2'b11);
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [5:0] a, input logic [7:0] d);
      @(negedge clk); reg_addr = a; reg_wdata = d; reg_we = 1'b1;
      @(negedge clk); reg_we = 1'b0;
   endtask

   task automatic rd(input logic [5:0] a, output logic [7:0] d);
      @(negedge clk); reg_addr = a; #1 d = reg_rdata;
   endtask

   task automatic wait_done();
      logic [7:0] v;
      for (int i = 0; i < 4000; i++) begin
         rd(6'h1E, v);
         if (!v[7]) break;
      end
   endtask

   task automatic prog(input logic [7:0] cmd, input logic [23:0] adr, input logic [31:0] dat);
      wr(6'h16, cmd);
      for (int k = 0; k < 3; k++) wr(6'h17 + 6'(k), adr[k*8 +: 8]);
      for (int k = 0; k < 4; k++) wr(6'h1A + 6'(k), dat[k*8 +: 8]);
   endtask

   // full transaction against the model, shape = control bits 6:0
   task automatic txn(input logic [7:0] cmd, input logic [23:0] adr, input logic [31:0] dat,
                      input logic [6:0] shape, input logic alt, input logic use_alias);
      logic [7:0] eb [8];
      logic [7:0] v, e;
      int n, nc, na, nd;
      logic dev;
      prog(cmd, adr, dat);
      wr(6'h1F, {5'b0, alt, 2'b11});
      nc = shape[4] ? 0 : 1;
      na = shape[3] ? 3 : 0;
      nd = (shape[2:0] > 3'd4) ? 4 : int'(shape[2:0]);
      n = 0;
      if (nc == 1) begin eb[n] = cmd; n++; end
      if (na == 3) for (int k = 2; k >= 0; k--) begin eb[n] = adr[k*8 +: 8]; n++; end
      for (int k = 0; k < nd; k++) begin eb[n] = shape[5] ? dat[k*8 +: 8] : 8'h00; n++; end
      dev = alt | shape[6];
      exp_cs = dev ? 2'b01 : 2'b10;
      salt = 8'($urandom);
      sbit = 0; mbits = 0; cs_bad = 0;
      wr(6'h1E, {1'b1, shape});
      wait_done();
      chk("R5 sck pulse count", mbits, n * 8);
      for (int i = 0; i < n && i < 8; i++)
         chk(i < nc ? "R3 command byte" : (i < nc + na ? "R3 address byte" : "R4 data out byte"),
             mlog[i], eb[i]);
      chk("R6 select device", cs_bad, 0);
      chk("R6 select idle", spi_cs_n, 2'b11);
      rd(6'h1E, v);
      chk("R5 control readback", v, {1'b0, shape});
      for (int k = 0; k < 4; k++) begin
         rd((use_alias ? 6'h20 : 6'h1A) + 6'(k), v);
         e = (!shape[5] && k < nd) ? resp(nc + na + k, salt) : dat[k*8 +: 8];
         chk(use_alias ? "R2 wide view data" : "R4 data in byte", v, e);
      end
      exp_cs = 2'b11;
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      summary();
      $finish;
   end

   initial begin
      logic [7:0] v;
      void'($urandom(32'd2024));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(6'h1E, v); chk("R1 control reset", v, 8'h00);
      rd(6'h1F, v); chk("R1 extended reset", v, 8'h03);
      chk("R1 selects high", spi_cs_n, 2'b11);
      chk("R1 sck low", spi_sck, 1'b0);
      rd(6'h05, v); chk("R2 unmapped reads zero", v, 8'h00);

      // directed: full shape, address order, clamp of count 7 to 4
      txn(8'h0B, 24'h123456, 32'hDDCCBBAA, 7'b0101111, 1'b0, 1'b0);
      txn(8'h03, 24'hABCDEF, 32'h44332211, 7'b0001100, 1'b0, 1'b1);
      // R5 zero-byte transaction
      txn(8'h06, 24'h0, 32'h0, 7'b0010000, 1'b0, 1'b0);
      // R6 secondary select routes to device 1 with bit 6 clear
      txn(8'h05, 24'h0, 32'h0, 7'b0000001, 1'b1, 1'b0);

      // R8 writes while busy are ignored
      prog(8'hA1, 24'h010203, 32'h0);
      wr(6'h1F, 8'h03);
      exp_cs = 2'b10; sbit = 0; mbits = 0; cs_bad = 0;
      wr(6'h1E, 8'h88);
      rd(6'h1E, v); chk("R5 busy bit during run", v[7], 1'b1);
      wr(6'h16, 8'h5E);
      wr(6'h18, 8'h77);
      wr(6'h1E, 8'hC4);
      wr(6'h1B, 8'h99);
      wait_done();
      exp_cs = 2'b11;
      chk("R8 command sent unchanged", mlog[0], 8'hA1);
      chk("R8 address sent unchanged", mlog[2], 8'h02);
      chk("R8 pulse count unchanged", mbits, 32);
      rd(6'h16, v); chk("R8 command kept", v, 8'hA1);
      rd(6'h18, v); chk("R8 address kept", v, 8'h02);
      rd(6'h1E, v); chk("R8 control kept", v, 8'h08);
      rd(6'h1B, v); chk("R8 data kept", v, 8'h00);

      // R9 lock
      wr(6'h1F, 8'h0B);
      wr(6'h16, 8'h55); rd(6'h16, v); chk("R9 command locked", v, 8'hA1);
      wr(6'h17, 8'h66); rd(6'h17, v); chk("R9 address locked", v, 8'h03);
      wr(6'h21, 8'h67); rd(6'h1B, v); chk("R9 data locked", v, 8'h00);
      wr(6'h1E, 8'h12); rd(6'h1E, v); chk("R9 control writable", v, 8'h12);
      rd(6'h1F, v); chk("R9 extended writable", v, 8'h0B);
      wr(6'h1F, 8'h03);
      wr(6'h16, 8'h55); rd(6'h16, v); chk("R9 unlocked write", v, 8'h55);

      // R7 software select held across two transactions
      wr(6'h1F, 8'h01);
      chk("R7 software select idle", spi_cs_n, 2'b01);
      wr(6'h16, 8'h9F);
      exp_cs = 2'b01; sbit = 0; mbits = 0; cs_bad = 0; salt = 8'h5A;
      wr(6'h1E, 8'hE0);
      wait_done();
      chk("R7 held between transactions", spi_cs_n, 2'b01);
      wr(6'h1E, 8'hD1);
      wait_done();
      chk("R7 command of chained op", mlog[0], 8'h9F);
      chk("R7 chained pulse count", mbits, 16);
      chk("R7 chained select", cs_bad, 0);
      rd(6'h1A, v); chk("R7 chained read byte", v, resp(1, 8'h5A));
      wr(6'h1F, 8'h03);
      chk("R7 release", spi_cs_n, 2'b11);
      exp_cs = 2'b11;

      // random shapes
      for (int t = 0; t < 40; t++) begin
         txn(8'($urandom), 24'($urandom), $urandom, 7'($urandom),
             1'($urandom), 1'($urandom));
      end

      chk("R6 setup before first edge", setup_bad, 0);
      chk("R6 hold after last edge", hold_bad, 0);
      chk("R10 high time", hi_bad, 0);
      chk("R10 low time", lo_bad, 0);
      summary();
      $finish;
   end
endmodule